// File: doc/BRIEF.md
# Watchdog Timer with Interrupt-Then-Reset Escalation

This block watches for software that has stopped running. Once enabled, an 18-bit up counter advances on every watchdog clock. When it reaches a programmable power-of-two interval, a sticky timeout flag is set. The flag can raise an interrupt, and it can also produce a wake-up pulse. The block then starts a second, shorter grace timer. If software restarts the counter before the grace timer expires, nothing more happens. If the grace timer expires and the reset enable is set, the block emits a one-cycle system reset request.

Software restarts the counter by writing a fixed key to a write-only kick register. Enable, disable and kick commands pass through a short command pipeline, so each takes effect a fixed number of clocks after its write. A busy bit shows whether an enable or disable is still on its way through. A debug-halt input freezes both timers unless a control bit tells the block to ignore it.

The block runs entirely on the watchdog clock. Registers are addressed by a 2-bit word index: 0 is control, 1 is the grace select, 2 is the kick register. Reads are combinational.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word and the grace-select word read 0, and `irq`, `wake_pulse` and `sys_rst_req` are 0.
- R2: The timeout select in control bits 10:8 (code n) sets an interval of 2^(4+2n) clocks. The timeout flag (control bit 3) becomes visible 2 + 2^(4+2n) clocks after the write that sets the enable bit (control bit 7).
- R3: `irq` equals the timeout flag ANDed with the interrupt enable (control bit 6).
- R4: The grace select (word 1, bits 1:0) gives a grace of 1026, 130, 18 or 3 clocks for codes 0, 1, 2 and 3. With reset enable (control bit 1) set, `sys_rst_req` is a one-cycle pulse visible exactly that many clocks after the timeout flag appears.
- R5: A reset request sets the sticky reset flag (control bit 2), returns the grace select to 0 and restarts counting. With reset enable clear, no request and no reset flag result.
- R6: Writing exactly 0x00005AA5 to word 2 clears the counter; the next timeout then comes 2 + interval clocks after that write. Any other value written to word 2 has no effect on the timing.
- R7: The reset flag (bit 2), timeout flag (bit 3) and wake flag (bit 5) are cleared by writing 1 to that bit. Writing 0 leaves them unchanged. A flag being set wins over a clear in the same cycle.
- R8: Clearing the enable bit stops the counter and zeroes it. No timeout occurs while the block is disabled, and re-enabling restarts the full interval.
- R9: The sync bit (control bit 30) reads 1 for the 2 clocks after a control write and reads 0 afterwards.
- R10: With wake enable (control bit 4) and interrupt enable both set, a timeout produces a one-cycle `wake_pulse` in the same cycle the timeout flag appears, and sets the wake flag (bit 5).
- R11: With the debug-free bit (control bit 31) at 0, both timers hold while `dbg_halt` is 1. With it at 1, `dbg_halt` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word index (0 control, 1 grace select, 2 kick) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word index |
| rd_data | output | 32 | Combinational read data |
| dbg_halt | input | 1 | Debugger halt indication |
| irq | output | 1 | Timeout interrupt |
| wake_pulse | output | 1 | One-cycle wake-up pulse |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Latencies are counted in edges from the write that starts them:
- The timeout flag, `irq` and `wake_pulse` appear 2 + interval edges after an enable or good-key kick.
- `sys_rst_req` follows the flag after exactly the grace count.
- The sync bit is high for 2 edges after a control write.
- A debug halt of h edges pushes the timeout out by h.

The bench drives every input on the falling edge and counts falling edges until the output changes. It compares that count with the exact figure. Results that should be absent are watched for a window longer than the interval they would need.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W   = 18;
    localparam int GRACE_W = 11;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int TSEL_W  = 3;
    localparam int DSEL_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ALT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_KICK = 2'd2;

    localparam int POS_RST_EN  = 1;
    localparam int POS_RST_FLG = 2;
    localparam int POS_TO_FLG  = 3;
    localparam int POS_WK_EN   = 4;
    localparam int POS_WK_FLG  = 5;
    localparam int POS_INT_EN  = 6;
    localparam int POS_EN      = 7;
    localparam int POS_TSEL    = 8;
    localparam int POS_SYNC    = 30;
    localparam int POS_DBG     = 31;

    typedef struct packed {
        logic              dbg_free;
        logic [TSEL_W-1:0] tsel;
        logic              int_en;
        logic              wake_en;
        logic              rst_en;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GRACE = 2'd2
    } phase_t;

    // Last counter value before the interval elapses: 2^(4+2n) - 1
    function automatic logic [CNT_W-1:0] last_tick(input logic [TSEL_W-1:0] sel);
        logic [CNT_W:0] one;
        logic [4:0]     sh;
        one = (CNT_W+1)'(1);
        sh  = 5'd4 + {1'b0, sel, 1'b0};
        return CNT_W'((one << sh) - one);
    endfunction

    // Last grace value before expiry: grace length minus one
    function automatic logic [GRACE_W-1:0] grace_last(input logic [DSEL_W-1:0] sel);
        logic [GRACE_W-1:0] r;
        unique case (sel)
            2'd0:    r = 11'd1025;
            2'd1:    r = 11'd129;
            2'd2:    r = 11'd17;
            default: r = 11'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int               CMD_STAGES = 2,
    parameter logic [DATA_W-1:0] KICK_KEY  = 32'h0000_5AA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              timeout_evt,
    input  logic              expire_evt,
    output cfg_t              cfg,
    output logic [DSEL_W-1:0] dsel,
    output logic              en_apply,
    output logic              en_val,
    output logic              kick_apply,
    output logic              irq,
    output logic              wake_pulse
);

    localparam int LAST = CMD_STAGES - 1;

    logic                  run_req;
    logic                  to_flag;
    logic                  rst_flag;
    logic                  wake_flag;
    logic                  wake_q;
    logic [CMD_STAGES-1:0] en_v;
    logic [CMD_STAGES-1:0] en_d;
    logic [CMD_STAGES-1:0] kk_v;
    logic                  ctl_wr;
    logic                  alt_wr;
    logic                  kick_ok;
    logic                  rst_hit;
    logic                  wake_hit;
    logic                  sync_busy;
    logic                  unused_bits;

    assign unused_bits = ^{wr_data[0], wr_data[29:11]};

    always_comb begin
        ctl_wr    = wr_en && (wr_addr == ADDR_CTL);
        alt_wr    = wr_en && (wr_addr == ADDR_ALT);
        kick_ok   = wr_en && (wr_addr == ADDR_KICK) && (wr_data == KICK_KEY);
        rst_hit   = expire_evt && cfg.rst_en;
        wake_hit  = timeout_evt && cfg.wake_en && cfg.int_en;
        sync_busy = |en_v;
    end

    // Configuration and sticky flags
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            run_req   <= 1'b0;
            to_flag   <= 1'b0;
            rst_flag  <= 1'b0;
            wake_flag <= 1'b0;
            wake_q    <= 1'b0;
            dsel      <= '0;
        end else begin
            wake_q <= wake_hit;
            if (ctl_wr) begin
                cfg.rst_en   <= wr_data[POS_RST_EN];
                cfg.wake_en  <= wr_data[POS_WK_EN];
                cfg.int_en   <= wr_data[POS_INT_EN];
                cfg.tsel     <= wr_data[POS_TSEL +: TSEL_W];
                cfg.dbg_free <= wr_data[POS_DBG];
                run_req      <= wr_data[POS_EN];
            end
            if (timeout_evt)
                to_flag <= 1'b1;
            else if (ctl_wr && wr_data[POS_TO_FLG])
                to_flag <= 1'b0;
            if (rst_hit)
                rst_flag <= 1'b1;
            else if (ctl_wr && wr_data[POS_RST_FLG])
                rst_flag <= 1'b0;
            if (wake_hit)
                wake_flag <= 1'b1;
            else if (ctl_wr && wr_data[POS_WK_FLG])
                wake_flag <= 1'b0;
            if (rst_hit)
                dsel <= '0;
            else if (alt_wr)
                dsel <= wr_data[DSEL_W-1:0];
        end
    end

    // Command pipeline: enable changes and kicks land CMD_STAGES clocks late
    always_ff @(posedge clk) begin
        if (rst) begin
            en_v <= '0;
            en_d <= '0;
            kk_v <= '0;
        end else begin
            for (int i = LAST; i > 0; i--) begin
                en_v[i] <= en_v[i-1];
                en_d[i] <= en_d[i-1];
                kk_v[i] <= kk_v[i-1];
            end
            en_v[0] <= ctl_wr;
            en_d[0] <= wr_data[POS_EN];
            kk_v[0] <= kick_ok;
        end
    end

    assign en_apply   = en_v[LAST];
    assign en_val     = en_d[LAST];
    assign kick_apply = kk_v[LAST];
    assign irq        = to_flag && cfg.int_en;
    assign wake_pulse = wake_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTL: begin
                rd_data[POS_RST_EN]              = cfg.rst_en;
                rd_data[POS_RST_FLG]             = rst_flag;
                rd_data[POS_TO_FLG]              = to_flag;
                rd_data[POS_WK_EN]               = cfg.wake_en;
                rd_data[POS_WK_FLG]              = wake_flag;
                rd_data[POS_INT_EN]              = cfg.int_en;
                rd_data[POS_EN]                  = run_req;
                rd_data[POS_TSEL +: TSEL_W]      = cfg.tsel;
                rd_data[POS_SYNC]                = sync_busy;
                rd_data[POS_DBG]                 = cfg.dbg_free;
            end
            ADDR_ALT: rd_data[DSEL_W-1:0] = dsel;
            default:  rd_data = '0;
        endcase
    end

    // R9
    sync_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> sync_busy);

    // R7
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_evt |=> to_flag);

    // R5
    reset_event_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_evt && cfg.rst_en) |=> (rst_flag && dsel == '0));

    // R10
    wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (to_flag && wake_flag && $past(cfg.int_en && cfg.wake_en)));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_apply,
    input  logic              en_val,
    input  logic              kick_apply,
    input  logic              dbg_free,
    input  logic              dbg_halt,
    input  logic              rst_en,
    input  logic [TSEL_W-1:0] tsel,
    input  logic [DSEL_W-1:0] dsel,
    output logic              timeout_evt,
    output logic              expire_evt,
    output logic              sys_rst_req
);

    phase_t             phase;
    logic [CNT_W-1:0]   cnt;
    logic [GRACE_W-1:0] grace;
    logic               tick;
    logic               stop_cmd;
    logic               start_cmd;
    logic               kick_cmd;
    logic               cmd_take;

    always_comb begin
        tick        = dbg_free || !dbg_halt;
        stop_cmd    = en_apply && !en_val;
        start_cmd   = en_apply && en_val && (phase == ST_IDLE);
        kick_cmd    = kick_apply && (phase != ST_IDLE);
        cmd_take    = stop_cmd || start_cmd || kick_cmd;
        timeout_evt = !cmd_take && tick && (phase == ST_COUNT) && (cnt == last_tick(tsel));
        expire_evt  = !cmd_take && tick && (phase == ST_GRACE) && (grace == grace_last(dsel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= ST_IDLE;
            cnt         <= '0;
            grace       <= '0;
            sys_rst_req <= 1'b0;
        end else begin
            sys_rst_req <= expire_evt && rst_en;
            if (stop_cmd) begin
                phase <= ST_IDLE;
                cnt   <= '0;
                grace <= '0;
            end else if (start_cmd || kick_cmd) begin
                phase <= ST_COUNT;
                cnt   <= '0;
                grace <= '0;
            end else if (tick) begin
                unique case (phase)
                    ST_COUNT: begin
                        if (timeout_evt) begin
                            phase <= ST_GRACE;
                            cnt   <= '0;
                            grace <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_GRACE: begin
                        if (expire_evt) begin
                            phase <= ST_COUNT;
                            grace <= '0;
                        end else begin
                            grace <= grace + GRACE_W'(1);
                        end
                    end
                    default: begin
                        cnt   <= '0;
                        grace <= '0;
                    end
                endcase
            end
        end
    end

    // R4
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    // R5
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(rst_en));

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!dbg_free && dbg_halt && !en_apply && !kick_apply) |=> ($stable(cnt) && $stable(grace)));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |-> (cnt == '0 && grace == '0 && !timeout_evt));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int                CMD_STAGES = 2,
    parameter logic [DATA_W-1:0] KICK_KEY   = 32'h0000_5AA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              wake_pulse,
    output logic              sys_rst_req
);

    cfg_t              cfg;
    logic [DSEL_W-1:0] dsel;
    logic              en_apply;
    logic              en_val;
    logic              kick_apply;
    logic              timeout_evt;
    logic              expire_evt;

    wdog_regs #(
        .CMD_STAGES (CMD_STAGES),
        .KICK_KEY   (KICK_KEY)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .timeout_evt (timeout_evt),
        .expire_evt  (expire_evt),
        .cfg         (cfg),
        .dsel        (dsel),
        .en_apply    (en_apply),
        .en_val      (en_val),
        .kick_apply  (kick_apply),
        .irq         (irq),
        .wake_pulse  (wake_pulse)
    );

    wdog_core u_core (
        .clk         (clk),
        .rst         (rst),
        .en_apply    (en_apply),
        .en_val      (en_val),
        .kick_apply  (kick_apply),
        .dbg_free    (cfg.dbg_free),
        .dbg_halt    (dbg_halt),
        .rst_en      (cfg.rst_en),
        .tsel        (cfg.tsel),
        .dsel        (dsel),
        .timeout_evt (timeout_evt),
        .expire_evt  (expire_evt),
        .sys_rst_req (sys_rst_req)
    );

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> cfg.int_en);

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        irq;
    logic        wake_pulse;
    logic        sys_rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .dbg_halt    (dbg_halt),
        .irq         (irq),
        .wake_pulse  (wake_pulse),
        .sys_rst_req (sys_rst_req)
    );

    typedef struct packed {
        logic [2:0] tsel;
        logic [1:0] dsel;
        int         tmo;
        int         grc;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{tsel: 3'd0, dsel: 2'd3, tmo: 18,  grc: 3},
        '{tsel: 3'd1, dsel: 2'd3, tmo: 66,  grc: 3},
        '{tsel: 3'd2, dsel: 2'd3, tmo: 258, grc: 3},
        '{tsel: 3'd0, dsel: 2'd2, tmo: 18,  grc: 18},
        '{tsel: 3'd0, dsel: 2'd1, tmo: 18,  grc: 130},
        '{tsel: 3'd0, dsel: 2'd0, tmo: 18,  grc: 1026}
    };

    function automatic logic [31:0] mk_ctl(bit en, logic [2:0] ts, bit ie, bit we,
                                           bit re, bit df, logic [2:0] clr);
        logic [31:0] v;
        v       = '0;
        v[1]    = re;
        v[2]    = clr[0];
        v[3]    = clr[1];
        v[4]    = we;
        v[5]    = clr[2];
        v[6]    = ie;
        v[7]    = en;
        v[10:8] = ts;
        v[31]   = df;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        rd_addr = 2'd0;
        #1;
    endtask

    // Counts falling edges until the chosen output is 1 (0 irq, 1 reset, 2 wake)
    task automatic measure(input int which, input int limit, output int n, output bit seen);
        bit s;
        n = 0;
        seen = 1'b0;
        do begin
            @(negedge clk);
            n++;
            s = (which == 0) ? irq : (which == 1) ? sys_rst_req : wake_pulse;
        end while (!s && n < limit);
        seen = s;
    endtask

    task automatic quiesce();
        dbg_halt = 1'b0;
        wr(2'd0, mk_ctl(0, 3'd0, 0, 0, 0, 0, 3'b111));
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        bit seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d);
        chk(d == 32'd0, "R1 ctl after reset", int'(d), 0);
        rd(2'd1, d);
        chk(d == 32'd0, "R1 alt after reset", int'(d), 0);
        chk(!irq && !wake_pulse && !sys_rst_req, "R1 outputs idle",
            int'({irq, wake_pulse, sys_rst_req}), 0);

        // R2 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            quiesce();
            wr(2'd1, {30'd0, VECS[i].dsel});
            wr(2'd0, mk_ctl(1, VECS[i].tsel, 1, 0, 1, 0, 3'b000));
            measure(0, 2000, n, seen);
            chk(seen && n == VECS[i].tmo, "R2 timeout latency", n, VECS[i].tmo);
            measure(1, 2000, n, seen);
            chk(seen && n == VECS[i].grc, "R4 grace latency", n, VECS[i].grc);
            @(negedge clk);
            chk(!sys_rst_req, "R4 request one cycle", int'(sys_rst_req), 0);
            rd(2'd0, d);
            chk(d[2] == 1'b1, "R5 reset flag set", int'(d[2]), 1);
            rd(2'd1, d);
            chk(d[1:0] == 2'd0, "R5 grace select cleared", int'(d[1:0]), 0);
        end

        // R9 sync bit
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 0, 0, 0, 0, 3'b000));
        rd(2'd0, d);
        chk(d[30] == 1'b1, "R9 sync first cycle", int'(d[30]), 1);
        @(negedge clk);
        rd(2'd0, d);
        chk(d[30] == 1'b1, "R9 sync second cycle", int'(d[30]), 1);
        @(negedge clk);
        rd(2'd0, d);
        chk(d[30] == 1'b0, "R9 sync done", int'(d[30]), 0);

        // R3 irq gated by interrupt enable
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 0, 0, 0, 0, 3'b000));
        repeat (20) @(negedge clk);
        rd(2'd0, d);
        chk(d[3] == 1'b1 && !irq, "R3 flag without irq", int'({d[3], irq}), 2);

        // R7 W1C and R5 no request without reset enable
        quiesce();
        wr(2'd1, 32'd0);
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        measure(0, 100, n, seen);
        chk(seen && n == 18, "R2 timeout before clear test", n, 18);
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        chk(irq == 1'b1, "R7 write 0 keeps flag", int'(irq), 1);
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b010));
        chk(irq == 1'b0, "R7 write 1 clears flag", int'(irq), 0);
        measure(1, 1100, n, seen);
        chk(!seen, "R5 no request when disabled", int'(seen), 0);
        rd(2'd0, d);
        chk(d[2] == 1'b0, "R5 no reset flag", int'(d[2]), 0);

        // R6 kick: wrong key ignored, right key restarts
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        wr(2'd2, 32'h0000_5AA4);
        measure(0, 100, n, seen);
        chk(seen && n == 17, "R6 bad key ignored", n, 17);
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        repeat (5) @(negedge clk);
        wr(2'd2, 32'h0000_5AA5);
        measure(0, 100, n, seen);
        chk(seen && n == 18, "R6 key restarts count", n, 18);

        // R8 disable stops and clears
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        repeat (8) @(negedge clk);
        wr(2'd0, mk_ctl(0, 3'd0, 1, 0, 0, 0, 3'b000));
        measure(0, 100, n, seen);
        chk(!seen, "R8 no timeout when disabled", int'(seen), 0);
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        measure(0, 100, n, seen);
        chk(seen && n == 18, "R8 full interval after re-enable", n, 18);

        // R10 wake pulse
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 1, 1, 0, 0, 3'b000));
        measure(2, 100, n, seen);
        chk(seen && n == 18 && irq, "R10 wake with timeout", n, 18);
        @(negedge clk);
        chk(!wake_pulse, "R10 wake one cycle", int'(wake_pulse), 0);
        rd(2'd0, d);
        chk(d[5] == 1'b1, "R10 wake flag", int'(d[5]), 1);
        wr(2'd0, mk_ctl(1, 3'd0, 1, 1, 0, 0, 3'b100));
        rd(2'd0, d);
        chk(d[5] == 1'b0, "R7 wake flag cleared", int'(d[5]), 0);

        // R11 debug halt honoured, then ignored
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 0, 3'b000));
        repeat (4) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (10) @(negedge clk);
        dbg_halt = 1'b0;
        measure(0, 100, n, seen);
        chk(seen && n == 14, "R11 halt stretches timeout", n, 14);
        quiesce();
        wr(2'd0, mk_ctl(1, 3'd0, 1, 0, 0, 1, 3'b000));
        repeat (4) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (10) @(negedge clk);
        dbg_halt = 1'b0;
        measure(0, 100, n, seen);
        chk(seen && n == 4, "R11 halt ignored when free", n, 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule